// File: doc/BRIEF.md
# Register Front End for a Byte-Stream Serial Port

This block is the software-facing side of a simple serial port. A processor uses a plain read/write strobe interface with 32-bit word registers to load bytes into a transmit queue and take bytes out of a receive queue. It also sets the port enables, the stop-bit choice, the queue watermarks and the baud divisor. Toward the serial engine, the block offers transmitted bytes on a valid/ready pair. It accepts received bytes on a data bus qualified by a single-cycle valid strobe. It passes the enables, the stop-bit choice and the divisor straight out to the engine.

Each data register carries its queue status in bit 31. A single read of the receive register therefore both removes a byte and tells software whether a byte was there at all. The block raises interrupts only from queue fill levels compared against programmable watermarks. The result is one level-sensitive interrupt line.

Top module: `serial_front`

## Requirements
- R1: After reset, every register reads zero, the pending register reads zero, `irq` is 0, `txValid` is 0, and the enables, `twoStop` and `divisor` outputs are 0.
- R2: A write to byte address 0x00 enqueues `busWdata[7:0]` into an 8-entry transmit queue. A read of 0x00 returns bit 31 set exactly when the queue holds 8 bytes. A write while the queue is full is dropped.
- R3: Bytes leave the transmit queue on `txData` in write order, one per cycle in which `txValid` and `txReady` are both 1. `txValid` is 0 while transmit enable is 0. While a byte is offered and not taken, `txValid` stays 1 and `txData` holds.
- R4: A read of byte address 0x04 returns the oldest received byte in bits [7:0] and removes it, with bit 31 = 0. When the receive queue is empty, the read returns bit 31 = 1 and changes nothing.
- R5: A byte on `rxData` with `rxValid` = 1 enters the 8-entry receive queue only when receive enable is 1 and the queue is not full. Otherwise it is discarded.
- R6: Transmit control at 0x08 holds the enable in bit 0, the stop select in bit 1 (1 = two stop bits, driven on `twoStop`) and a 3-bit watermark in bits [18:16]. Receive control at 0x0C holds the enable in bit 0 and a 3-bit watermark in bits [18:16]. The divisor at 0x18 holds 16 bits, driven on `divisor`. Each register reads back what was written.
- R7: Pending bit 0 (transmit) at 0x14 is 1 exactly when the transmit queue count is less than the transmit watermark. With a watermark of 1, it is 1 exactly when the queue is empty.
- R8: Pending bit 1 (receive) is 1 exactly when the receive queue count is greater than the receive watermark. With a watermark of 0, it is 1 as soon as one byte waits.
- R9: The interrupt enable register at 0x10 uses bit 0 for transmit and bit 1 for receive. `irq` is 1 exactly when some pending bit is 1 and its enable bit is 1. The pending register ignores writes.
- R10: Register bits without a defined field read as zero. Any address outside the seven registers reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the strobe cycle |
| txValid | output | 1 | A transmit byte is offered |
| txReady | input | 1 | Engine takes the offered byte |
| txData | output | 8 | Offered transmit byte |
| rxValid | input | 1 | Received byte strobe |
| rxData | input | 8 | Received byte |
| txEnable | output | 1 | Transmit enable to the engine |
| rxEnable | output | 1 | Receive enable to the engine |
| twoStop | output | 1 | 1 = two stop bits |
| divisor | output | 16 | Baud divisor |
| irq | output | 1 | Watermark interrupt, level |

## Verification
Directed sequences drive each queue through the empty state, part-filled states, the exact full state and one or two extra bytes past full. Each comparison therefore separates a correct boundary from an off-by-one in the full flag, the drop rule or the watermark inequalities. Receive watermarks of 2 and transmit watermarks of 1 are tried against the live fill level, with each interrupt enable on and off, to show that each pending bit is masked only by its own enable. A seeded random phase then mixes transmit writes, engine pops, engine pushes, receive reads and watermark changes. After every step it compares the pending register and `irq` against a queue model, which catches ordering errors and any mismatch between simultaneous queue activity and the pending rules.

// File: rtl/serial_front_pkg.sv
package serial_front_pkg;

  // Register byte offsets (software decodes these)
  localparam logic [4:0] OFF_TXDATA = 5'h00;
  localparam logic [4:0] OFF_RXDATA = 5'h04;
  localparam logic [4:0] OFF_TXCTRL = 5'h08;
  localparam logic [4:0] OFF_RXCTRL = 5'h0C;
  localparam logic [4:0] OFF_IRQEN  = 5'h10;
  localparam logic [4:0] OFF_IRQPND = 5'h14;
  localparam logic [4:0] OFF_DIVSR  = 5'h18;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned WM_LSB   = 16;
  localparam int unsigned FLAG_BIT = 31;

  // Strobes from control to datapath
  typedef struct packed {
    logic              txPush;
    logic [BYTE_W-1:0] txByte;
    logic              rxPop;
  } strobe_t;

endpackage

// File: rtl/serial_front_fifo.sv
module serial_front_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPush, doPop;

  assign doPush = push && (count != CNT_W'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign head   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

endmodule

// File: rtl/serial_front_dpath.sv
module serial_front_dpath
  import serial_front_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              txEnable,
  input  logic              rxEnable,
  output logic              txValid,
  input  logic              txReady,
  output logic [BYTE_W-1:0] txData,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic [BYTE_W-1:0] rxHead
);

  logic txPop, rxPush;

  assign txValid = txEnable && (txCount != '0);
  assign txPop   = txValid && txReady;
  assign rxPush  = rxValid && rxEnable;

  serial_front_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) txQueue (
    .clk(clk), .rstN(rstN),
    .push(strobes.txPush), .pushData(strobes.txByte),
    .pop(txPop), .head(txData), .count(txCount)
  );

  serial_front_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) rxQueue (
    .clk(clk), .rstN(rstN),
    .push(rxPush), .pushData(rxData),
    .pop(strobes.rxPop), .head(rxHead), .count(rxCount)
  );

endmodule

// File: rtl/serial_front_ctrl.sv
module serial_front_ctrl
  import serial_front_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned WM_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [BYTE_W-1:0] rxHead,
  output strobe_t           strobes,
  output logic              txEnable,
  output logic              rxEnable,
  output logic              twoStop,
  output logic [DIV_W-1:0]  divisor,
  output logic              irq
);

  logic [WM_W-1:0] txWm, rxWm;
  logic [1:0]      irqEn, pending;
  logic            wrEn, rdEn, txFull, rxEmpty;
  logic            unusedWdata;

  assign unusedWdata = ^busWdata[31:WM_LSB+WM_W];
  assign wrEn    = busSel && busWrite;
  assign rdEn    = busSel && !busWrite;
  assign txFull  = (txCount == CNT_W'(DEPTH));
  assign rxEmpty = (rxCount == '0);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [4:0] off);
    return a == ADDR_W'(off);
  endfunction

  // Strobes toward the queues
  always_comb begin
    strobes.txPush = wrEn && hit(busAddr, OFF_TXDATA) && !txFull;
    strobes.txByte = busWdata[BYTE_W-1:0];
    strobes.rxPop  = rdEn && hit(busAddr, OFF_RXDATA) && !rxEmpty;
  end

  // Watermark conditions
  assign pending[0] = txCount < CNT_W'(txWm);
  assign pending[1] = rxCount > CNT_W'(rxWm);
  assign irq        = |(pending & irqEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEnable <= 1'b0;
      twoStop  <= 1'b0;
      txWm     <= '0;
      rxEnable <= 1'b0;
      rxWm     <= '0;
      irqEn    <= '0;
      divisor  <= '0;
    end else if (wrEn) begin
      if (hit(busAddr, OFF_TXCTRL)) begin
        txEnable <= busWdata[0];
        twoStop  <= busWdata[1];
        txWm     <= busWdata[WM_LSB +: WM_W];
      end
      if (hit(busAddr, OFF_RXCTRL)) begin
        rxEnable <= busWdata[0];
        rxWm     <= busWdata[WM_LSB +: WM_W];
      end
      if (hit(busAddr, OFF_IRQEN)) irqEn   <= busWdata[1:0];
      if (hit(busAddr, OFF_DIVSR)) divisor <= busWdata[DIV_W-1:0];
    end
  end

  // Read mux
  always_comb begin
    busRdata = '0;
    if (hit(busAddr, OFF_TXDATA)) begin
      busRdata[FLAG_BIT] = txFull;
    end else if (hit(busAddr, OFF_RXDATA)) begin
      busRdata[FLAG_BIT]     = rxEmpty;
      busRdata[BYTE_W-1:0]   = rxHead;
    end else if (hit(busAddr, OFF_TXCTRL)) begin
      busRdata[0]                = txEnable;
      busRdata[1]                = twoStop;
      busRdata[WM_LSB +: WM_W]   = txWm;
    end else if (hit(busAddr, OFF_RXCTRL)) begin
      busRdata[0]                = rxEnable;
      busRdata[WM_LSB +: WM_W]   = rxWm;
    end else if (hit(busAddr, OFF_IRQEN)) begin
      busRdata[1:0] = irqEn;
    end else if (hit(busAddr, OFF_IRQPND)) begin
      busRdata[1:0] = pending;
    end else if (hit(busAddr, OFF_DIVSR)) begin
      busRdata[DIV_W-1:0] = divisor;
    end
  end

endmodule

// File: rtl/serial_front.sv
module serial_front
  import serial_front_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              txEnable,
  output logic              rxEnable,
  output logic              twoStop,
  output logic [DIV_W-1:0]  divisor,
  output logic              irq
);

  strobe_t           strobes;
  logic [CNT_W-1:0]  txCount, rxCount;
  logic [BYTE_W-1:0] rxHead;

  serial_front_ctrl #(.DEPTH(DEPTH), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead),
    .strobes(strobes),
    .txEnable(txEnable), .rxEnable(rxEnable), .twoStop(twoStop),
    .divisor(divisor), .irq(irq)
  );

  serial_front_dpath #(.DEPTH(DEPTH)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .txEnable(txEnable), .rxEnable(rxEnable),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .rxValid(rxValid), .rxData(rxData),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead)
  );

endmodule

// File: rtl/serial_front_chk.sv
module serial_front_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic              txValid,
  input logic              txReady,
  input logic [7:0]        txData,
  input logic              txEnable,
  input logic              rxValid,
  input logic              rxEnable,
  input logic [CNT_W-1:0]  txCount,
  input logic [CNT_W-1:0]  rxCount
);

  logic rxRead;
  assign rxRead = busSel && !busWrite && (busAddr == ADDR_W'(5'h04));

  // R2: transmit queue never exceeds its depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= CNT_W'(DEPTH));

  // R3: nothing offered while transmit is disabled
  a_r3_gated: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |-> !txValid);

  // R3: an offered byte that is not taken holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !(busSel && busWrite)) |=> (txValid && $stable(txData)));

  // R4: an empty receive queue stays empty without an accepted byte
  a_r4_empty_stays: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == '0 && !(rxValid && rxEnable)) |=> rxCount == '0);

  // R5: a full receive queue stays full unless read
  a_r5_full_discard: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == CNT_W'(DEPTH) && !rxRead) |=> rxCount == CNT_W'(DEPTH));

endmodule

bind serial_front serial_front_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
  .txValid(txValid), .txReady(txReady), .txData(txData), .txEnable(txEnable),
  .rxValid(rxValid), .rxEnable(rxEnable), .txCount(txCount), .rxCount(rxCount)
);

// File: tb/serial_front_test.sv
`timescale 1ns/1ps
module serial_front_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        txValid, txReady = 1'b0;
  logic [7:0]  txData;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        txEnable, rxEnable, twoStop, irq;
  logic [15:0] divisor;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  serial_front uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txValid(txValid), .txReady(txReady),
    .txData(txData), .rxValid(rxValid), .rxData(rxData), .txEnable(txEnable),
    .rxEnable(rxEnable), .twoStop(twoStop), .divisor(divisor), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk); busSel = 0;
  endtask

  task automatic rxIn(input logic [7:0] b);
    @(negedge clk); rxValid = 1; rxData = b;
    @(negedge clk); rxValid = 0;
  endtask

  task automatic txTake(output logic [7:0] b, output logic ok);
    @(negedge clk); ok = txValid; b = txData; txReady = 1;
    @(negedge clk); txReady = 0;
  endtask

  function automatic logic [1:0] expPend(int tc, int rc, int tw, int rw);
    return {rc > rw, tc < tw};
  endfunction

  task automatic finish;
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    logic        ok;
    logic [7:0]  txQ[$];
    logic [7:0]  rxQ[$];
    int tw, rw;
    logic [1:0] ie, ep;

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(irq == 0 && txValid == 0, "R1 irq/txValid", {irq, txValid}, 0);
    chk(txEnable == 0 && rxEnable == 0 && twoStop == 0 && divisor == 0, "R1 outputs",
        {txEnable, rxEnable, twoStop, divisor}, 0);
    rd(5'h08, d); chk(d == 0, "R1 txctrl", d, 0);
    rd(5'h14, d); chk(d == 0, "R1 pending", d, 0);
    rd(5'h18, d); chk(d == 0, "R1 divisor", d, 0);

    // R6 control registers, R10 reserved bits
    wr(5'h08, 32'h0005_0003);
    rd(5'h08, d); chk(d == 32'h0005_0003, "R6 txctrl readback", d, 32'h0005_0003);
    chk(twoStop == 1 && txEnable == 1, "R6 twoStop/txEnable", {twoStop, txEnable}, 2'b11);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, d); chk(d == 32'h0007_0003, "R10 txctrl reserved", d, 32'h0007_0003);
    wr(5'h18, 32'hABCD_1234);
    chk(divisor == 16'h1234, "R6 divisor out", divisor, 16'h1234);
    rd(5'h18, d); chk(d == 32'h0000_1234, "R10 divisor reserved", d, 32'h1234);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, d); chk(d == 32'h0007_0001, "R6 rxctrl readback", d, 32'h0007_0001);
    chk(rxEnable == 1, "R6 rxEnable", rxEnable, 1);
    rd(5'h1C, d); chk(d == 0, "R10 unmapped", d, 0);
    wr(5'h0C, 32'h0);

    // R7/R9 transmit watermark 1, transmit disabled
    wr(5'h08, 32'h0001_0000);
    rd(5'h14, d); chk(d == 1, "R7 empty pending", d, 1);
    chk(irq == 0, "R9 masked", irq, 0);
    wr(5'h10, 32'h1);
    chk(irq == 1, "R9 tx irq", irq, 1);
    wr(5'h14, 32'h0);
    rd(5'h14, d); chk(d == 1, "R9 pending ignores write", d, 1);
    for (int i = 0; i < 8; i++) begin
      wr(5'h00, 32'h40 + i);
      if (i == 0) begin
        rd(5'h14, d); chk(d == 0, "R7 not empty", d, 0);
        chk(irq == 0, "R9 irq drop", irq, 0);
      end
      if (i == 6) begin
        rd(5'h00, d); chk(d[31] == 0, "R2 not full at 7", d, 0);
      end
    end
    chk(txValid == 0, "R3 gated", txValid, 0);
    rd(5'h00, d); chk(d[31] == 1, "R2 full at 8", d, 32'h8000_0000);
    wr(5'h00, 32'hEE);
    wr(5'h08, 32'h0001_0001);
    for (int i = 0; i < 8; i++) begin
      txTake(b, ok);
      chk(ok && b == 8'(32'h40 + i), "R3 order", {ok, b}, {1'b1, 8'(32'h40 + i)});
    end
    txTake(b, ok); chk(ok == 0, "R2 full write dropped", ok, 0);
    rd(5'h14, d); chk(d == 1, "R7 drained", d, 1);

    // R8/R5/R4 receive
    wr(5'h0C, 32'h0002_0001);
    wr(5'h10, 32'h2);
    chk(irq == 0, "R9 tx masked by own enable", irq, 0);
    rxIn(8'h90); rxIn(8'h91);
    rd(5'h14, d); chk(d == 1, "R8 count 2 vs wm 2", d, 1);
    rxIn(8'h92);
    rd(5'h14, d); chk(d == 3, "R8 count 3 vs wm 2", d, 3);
    chk(irq == 1, "R9 rx irq", irq, 1);
    for (int i = 3; i < 10; i++) rxIn(8'h90 + 8'(i));
    for (int i = 0; i < 8; i++) begin
      rd(5'h04, d);
      chk(d == {24'h0, 8'h90 + 8'(i)}, "R4/R5 order, overflow dropped", d, {24'h0, 8'h90 + 8'(i)});
    end
    rd(5'h04, d); chk(d[31] == 1, "R4 empty flag", d, 32'h8000_0000);
    rd(5'h04, d); chk(d[31] == 1, "R4 empty stays", d, 32'h8000_0000);
    wr(5'h0C, 32'h0);
    rxIn(8'h55);
    rd(5'h04, d); chk(d[31] == 1, "R5 disabled discard", d, 32'h8000_0000);
    wr(5'h0C, 32'h0000_0001);
    rxIn(8'h66);
    rd(5'h14, d); chk(d[1] == 1, "R8 wm0 one byte", d, 2);
    rd(5'h04, d); chk(d == 32'h66, "R4 data", d, 32'h66);

    // Random phase
    void'($urandom(32'd77));
    tw = 1; rw = 0; ie = 2'b10;
    wr(5'h08, 32'h0001_0001);
    wr(5'h10, {30'b0, ie});
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 6)
        0: begin
          b = 8'($urandom);
          wr(5'h00, {24'h0, b});
          if (txQ.size() < 8) txQ.push_back(b);
        end
        1: begin
          txTake(b, ok);
          chk(ok == (txQ.size() > 0), "R3 random valid", ok, txQ.size() > 0);
          if (txQ.size() > 0) begin
            chk(b == txQ[0], "R3 random data", b, txQ[0]);
            void'(txQ.pop_front());
          end
        end
        2: begin
          b = 8'($urandom);
          rxIn(b);
          if (rxQ.size() < 8) rxQ.push_back(b);
        end
        3: begin
          rd(5'h04, d);
          if (rxQ.size() == 0) chk(d[31] == 1, "R4 random empty", d, 32'h8000_0000);
          else begin
            chk(d == {24'h0, rxQ[0]}, "R4 random data", d, {24'h0, rxQ[0]});
            void'(rxQ.pop_front());
          end
        end
        4: begin
          tw = int'($urandom % 8);
          wr(5'h08, (32'(tw) << 16) | 32'(($urandom % 2) << 1) | 32'h1);
        end
        default: begin
          rw = int'($urandom % 8);
          ie = 2'($urandom);
          wr(5'h0C, (32'(rw) << 16) | 32'h1);
          wr(5'h10, {30'b0, ie});
        end
      endcase
      ep = expPend(txQ.size(), rxQ.size(), tw, rw);
      rd(5'h14, d);
      chk(d == {30'b0, ep}, "R7/R8 random pending", d, {30'b0, ep});
      chk(irq == |(ep & ie), "R9 random irq", irq, |(ep & ie));
    end

    finish();
  end

endmodule